// File: doc/BRIEF.md
# Interrupt Group Cause/Mask Register File

This block is a single group of an interrupt controller. It takes up to 32 cause inputs and latches each one into a cause register. A control bit selects whether an input latches while it is high or only on its rising edge. Software reaches the group through a small register window whose registers sit at word-aligned byte offsets. From the latched causes and a mask, the block produces a group summary level. From the summary it can produce a single-cycle message-interrupt request. It also produces a per-cause request to abort the engine, which is gated by a separate abort mask.

Two registers act on the zero bits of the written word. A write to the mask-clear register unmasks every cause written as 0. A write to the cause register acknowledges every cause written as 0. Software therefore writes the complement of the causes it means to touch. The mask register itself is an ordinary read/write register, so masking is done with a read-modify-write OR. Two moderation fields in the control word are stored and read back but drive nothing.

Top module: `irq_grp_ctrl`

## Requirements
- R1: After reset the cause register reads 0, the mask (0x10) and the abort mask (0x30) read all ones, the control word (0x28) reads only the revision in bits [29:28], and summary, message request and abort requests are low.
- R2: With control bit 3 at 0 (level mode), an input that is high at a clock edge sets its cause bit. An input still high after an acknowledge sets the bit again.
- R3: With control bit 3 at 1 (edge mode), only a 0-to-1 transition of an input sets its cause bit. An input held high does not set the bit again after an acknowledge.
- R4: A write to the cause register (0x00) clears each cause bit whose written bit is 0 and leaves the bits written as 1 unchanged.
- R5: A write to the mask register (0x10) replaces the whole mask. A write to mask-clear (0x18) clears each mask bit written as 0 and never sets a mask bit. A read of 0x18 returns the mask.
- R6: The summary is high exactly when some cause bit is set while its mask bit is 0.
- R7: With control bit 5 at 1, each 0-to-1 transition of the summary raises the message request for exactly one cycle. With bit 5 at 0, the request stays low.
- R8: With control bit 0 at 1, a read of the cause register returns the causes and then clears the returned bits. With bit 0 at 0, reads leave the causes unchanged.
- R9: Abort request bit i is high exactly when cause bit i is set and abort-mask bit i (0x30, read/write) is 0.
- R10: Control bits [23:16] and [27:24] are read/write storage. Control bits [29:28] always read the revision parameter (default 2), and writes do not change them.
- R11: A cause event that arrives in the same cycle as a write that clears that cause takes priority, and the cause bit stays set.
- R12: Offsets that are not mapped read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_CAUSE | Cause inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (drives auto-clear) |
| reg_addr_i | input | ADDR_W | Byte offset inside the group window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| summary_o | output | 1 | Group summary level |
| msi_o | output | 1 | One-cycle message-interrupt request |
| abort_req_o | output | N_CAUSE | Per-cause engine-abort request |

## Verification
The bench targets the inverted write semantics. A design that used the written 1s in mask-clear or cause writes would unmask, or acknowledge, exactly the causes that were meant to stay untouched. It drives an edge-mode input that stays high across an acknowledge, so a design that latched on level would re-raise the cause. It also places a fresh event in the same cycle as a clearing write, so a design with clear priority would lose that event. The bench counts message-request cycles after a summary rise to catch a request that is held high, and it reads the cause register twice with auto-clear on and off to catch a clear that happens without a read or never happens.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFF_CAUSE = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h10;
  localparam logic [7:0] OFF_MCLR  = 8'h18;
  localparam logic [7:0] OFF_CTRL  = 8'h28;
  localparam logic [7:0] OFF_AMSK  = 8'h30;

  localparam int CTRL_AUTOCLR = 0;
  localparam int CTRL_EDGE    = 3;
  localparam int CTRL_MSI     = 5;
  localparam int CTRL_REV_LO  = 28;

  // bits software may store: autoclr, edge, msi, moder interval [23:16], resolution [27:24]
  localparam logic [DW-1:0] CTRL_WR_MASK = 32'h0FFF_0029;

  typedef struct packed {
    logic cause_wr;
    logic cause_rd;
    logic mask_wr;
    logic mclr_wr;
    logic ctrl_wr;
    logic amsk_wr;
  } reg_stb_t;
endpackage

// File: rtl/irq_grp_cause.sv
module irq_grp_cause #(
  parameter int N_CAUSE = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] irq_i,
  input  logic               edge_mode_i,
  input  logic [N_CAUSE-1:0] clr_i,
  output logic [N_CAUSE-1:0] cause_o
);
  logic [N_CAUSE-1:0] irq_q;
  logic [N_CAUSE-1:0] cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  for (genvar i = 0; i < N_CAUSE; i++) begin : g_bit
    logic set_b;
    assign set_b = edge_mode_i ? (irq_i[i] & ~irq_q[i]) : irq_i[i];
    // set beats clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cause_q[i] <= 1'b0;
      else if (set_b)     cause_q[i] <= 1'b1;
      else if (clr_i[i])  cause_q[i] <= 1'b0;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_grp_cfg.sv
module irq_grp_cfg
  import irq_grp_pkg::*;
#(
  parameter int N_CAUSE = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  reg_stb_t           stb_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [N_CAUSE-1:0] mask_o,
  output logic [N_CAUSE-1:0] abort_msk_o,
  output logic [DW-1:0]      ctrl_o
);
  logic [N_CAUSE-1:0] mask_q, amsk_q;
  logic [DW-1:0]      ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      amsk_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (stb_i.mask_wr)      mask_q <= wdata_i[N_CAUSE-1:0];
      else if (stb_i.mclr_wr) mask_q <= mask_q & wdata_i[N_CAUSE-1:0];
      if (stb_i.amsk_wr)      amsk_q <= wdata_i[N_CAUSE-1:0];
      if (stb_i.ctrl_wr)      ctrl_q <= wdata_i & CTRL_WR_MASK;
    end
  end

  assign mask_o      = mask_q;
  assign abort_msk_o = amsk_q;
  assign ctrl_o      = ctrl_q;
endmodule

// File: rtl/irq_grp_out.sv
module irq_grp_out #(
  parameter int N_CAUSE = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] cause_i,
  input  logic [N_CAUSE-1:0] mask_i,
  input  logic [N_CAUSE-1:0] abort_msk_i,
  input  logic               msi_en_i,
  output logic               summary_o,
  output logic               msi_o,
  output logic [N_CAUSE-1:0] abort_req_o
);
  logic summary_q;

  assign summary_o = |(cause_i & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) summary_q <= 1'b0;
    else         summary_q <= summary_o;
  end

  assign msi_o       = msi_en_i & summary_o & ~summary_q;
  assign abort_req_o = cause_i & ~abort_msk_i;
endmodule

// File: rtl/irq_grp_ctrl.sv
module irq_grp_ctrl
  import irq_grp_pkg::*;
#(
  parameter int         N_CAUSE = 32,
  parameter int         ADDR_W  = 6,
  parameter logic [1:0] REV     = 2'd2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CAUSE-1:0] irq_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               summary_o,
  output logic               msi_o,
  output logic [N_CAUSE-1:0] abort_req_o
);
  logic [7:0]         off;
  reg_stb_t           stb;
  logic [N_CAUSE-1:0] cause_q, mask_q, abort_msk_q, clr;
  logic [DW-1:0]      ctrl_q;
  logic               edge_mode, autoclr;

  assign off = 8'(reg_addr_i);

  always_comb begin
    stb          = '0;
    stb.cause_wr = reg_we_i && off == OFF_CAUSE;
    stb.cause_rd = reg_re_i && off == OFF_CAUSE;
    stb.mask_wr  = reg_we_i && off == OFF_MASK;
    stb.mclr_wr  = reg_we_i && off == OFF_MCLR;
    stb.ctrl_wr  = reg_we_i && off == OFF_CTRL;
    stb.amsk_wr  = reg_we_i && off == OFF_AMSK;
  end

  assign edge_mode = ctrl_q[CTRL_EDGE];
  assign autoclr   = ctrl_q[CTRL_AUTOCLR];

  // cause write clears zero bits; auto-clear read clears what was returned
  always_comb begin
    clr = '0;
    if (stb.cause_wr)                clr = ~reg_wdata_i[N_CAUSE-1:0];
    else if (stb.cause_rd && autoclr) clr = cause_q;
  end

  irq_grp_cause #(.N_CAUSE(N_CAUSE)) u_cause (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .edge_mode_i (edge_mode),
    .clr_i       (clr),
    .cause_o     (cause_q)
  );

  irq_grp_cfg #(.N_CAUSE(N_CAUSE)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (stb),
    .wdata_i     (reg_wdata_i),
    .mask_o      (mask_q),
    .abort_msk_o (abort_msk_q),
    .ctrl_o      (ctrl_q)
  );

  irq_grp_out #(.N_CAUSE(N_CAUSE)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cause_i     (cause_q),
    .mask_i      (mask_q),
    .abort_msk_i (abort_msk_q),
    .msi_en_i    (ctrl_q[CTRL_MSI]),
    .summary_o   (summary_o),
    .msi_o       (msi_o),
    .abort_req_o (abort_req_o)
  );

  always_comb begin
    unique case (off)
      OFF_CAUSE:          reg_rdata_o = DW'(cause_q);
      OFF_MASK, OFF_MCLR: reg_rdata_o = DW'(mask_q);
      OFF_CTRL:           reg_rdata_o = ctrl_q | (DW'(REV) << CTRL_REV_LO);
      OFF_AMSK:           reg_rdata_o = DW'(abort_msk_q);
      default:            reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_grp_chk.sv
module irq_grp_chk #(
  parameter int N_CAUSE = 32,
  parameter int ADDR_W  = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CAUSE-1:0] irq_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic               summary_o,
  input logic               msi_o,
  input logic [N_CAUSE-1:0] abort_req_o,
  input logic [N_CAUSE-1:0] cause_q,
  input logic [N_CAUSE-1:0] mask_q,
  input logic [N_CAUSE-1:0] abort_msk_q,
  input logic               edge_mode
);
  p_level_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode && |irq_i) |=> (($past(irq_i) & ~cause_q) == '0));

  p_mclr_no_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && 8'(reg_addr_i) == 8'h18) |=> ((mask_q & ~$past(mask_q)) == '0));

  p_summary_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    summary_o |-> (|(cause_q & ~mask_q)));

  p_msi_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |=> !msi_o);

  p_msi_summary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_o |-> summary_o);

  p_abort_armed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((abort_req_o & abort_msk_q) == '0) && ((abort_req_o & ~cause_q) == '0));
endmodule

bind irq_grp_ctrl irq_grp_chk #(.N_CAUSE(N_CAUSE), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .summary_o   (summary_o),
  .msi_o       (msi_o),
  .abort_req_o (abort_req_o),
  .cause_q     (cause_q),
  .mask_q      (mask_q),
  .abort_msk_q (abort_msk_q),
  .edge_mode   (edge_mode)
);

// File: tb/sim_irq_grp_ctrl.sv
module sim_irq_grp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          summary, msi;
  logic [N-1:0]  abort_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_grp_ctrl #(.N_CAUSE(N), .ADDR_W(AW), .REV(2'd2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .summary_o(summary), .msi_o(msi), .abort_req_o(abort_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    re = 1'b1; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] b);
    @(negedge clk);
    irq = b;
    @(negedge clk);
    irq = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    check("R1 summary", 32'(summary), 0);
    check("R1 msi", 32'(msi), 0);
    check("R1 abort", abort_req, 0);
    rd(8'h00, d); check("R1 cause", d, 0);
    rd(8'h10, d); check("R1 mask", d, 32'hFFFF_FFFF);
    rd(8'h30, d); check("R1 abort mask", d, 32'hFFFF_FFFF);
    rd(8'h28, d); check("R1 ctrl", d, 32'h2000_0000);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(8'h28, 0); wr(8'h00, 0);
    pulse(32'h8);
    rd(8'h00, d); check("R2 level latch", d, 32'h8);
    wr(8'h00, ~32'h8);
    rd(8'h00, d); check("R4 ack clears", d, 0);
    @(negedge clk); irq = 32'h10;
    wr(8'h00, ~32'h10);
    rd(8'h00, d); check("R2 level re-set", d, 32'h10);
    irq = '0;
    wr(8'h00, 0);
    pulse(32'h18);
    wr(8'h00, ~32'h8);
    rd(8'h00, d); check("R4 ones unchanged", d, 32'h10);
    wr(8'h00, 0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(8'h28, 32'h08); wr(8'h00, 0);
    @(negedge clk); irq = 32'h40;
    @(negedge clk); @(negedge clk);
    rd(8'h00, d); check("R3 edge latch", d, 32'h40);
    wr(8'h00, ~32'h40);
    rd(8'h00, d); check("R3 held high no re-set", d, 0);
    irq = '0;
    @(negedge clk);
    // R11: event in the same cycle as clear-all write
    irq = 32'h80; we = 1'b1; addr = AW'(8'h00); wdata = 0;
    @(negedge clk);
    we = 1'b0; irq = '0;
    rd(8'h00, d); check("R11 set wins over clear", d, 32'h80);
    wr(8'h00, 0);
    wr(8'h28, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h00, 0);
    pulse(32'h8);
    #1 check("R6 masked no summary", 32'(summary), 0);
    wr(8'h18, ~32'h8);
    rd(8'h10, d); check("R5 mask-clear zero bit", d, 32'hFFFF_FFF7);
    #1 check("R6 summary", 32'(summary), 1);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R5 mask-clear ones no change", d, 32'hFFFF_FFF7);
    wr(8'h10, 32'hFFFF_FFFF);
    #1 check("R6 remasked", 32'(summary), 0);
    wr(8'h10, 32'h0000_00F0);
    rd(8'h10, d); check("R5 mask overwrite", d, 32'h0000_00F0);
    #1 check("R6 unmasked by write", 32'(summary), 1);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h00, 0);
  endtask

  task automatic t_msi;
    wr(8'h28, 32'h20); wr(8'h00, 0);
    wr(8'h18, ~32'h2);
    pulse(32'h2);
    #1 check("R7 msi raised", 32'(msi), 1);
    check("R7 summary high", 32'(summary), 1);
    @(negedge clk); #1 check("R7 msi one cycle", 32'(msi), 0);
    wr(8'h00, ~32'h2);
    #1 check("R7 summary fell", 32'(summary), 0);
    wr(8'h28, 0);
    pulse(32'h2);
    #1 check("R7 msi disabled", 32'(msi), 0);
    check("R6 summary without msi", 32'(summary), 1);
    wr(8'h00, 0);
    wr(8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_autoclr;
    logic [31:0] d;
    wr(8'h28, 32'h01); wr(8'h00, 0);
    pulse(32'h4);
    rd(8'h00, d); check("R8 auto-clear first read", d, 32'h4);
    rd(8'h00, d); check("R8 auto-clear second read", d, 0);
    wr(8'h28, 0);
    pulse(32'h4);
    rd(8'h00, d); check("R8 plain read", d, 32'h4);
    rd(8'h00, d); check("R8 plain read keeps", d, 32'h4);
    wr(8'h00, 0);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    wr(8'h00, 0);
    pulse(32'h24);
    #1 check("R9 disarmed", abort_req, 0);
    wr(8'h30, ~32'h4);
    #1 check("R9 armed cause", abort_req, 32'h4);
    rd(8'h30, d); check("R9 abort mask readback", d, 32'hFFFF_FFFB);
    wr(8'h00, 0);
    #1 check("R9 no cause no abort", abort_req, 0);
    wr(8'h30, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctrl_store;
    logic [31:0] d;
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); check("R10 ctrl fields", d, 32'h2FFF_0029);
    wr(8'h28, 32'h3000_0000);
    rd(8'h28, d); check("R10 revision fixed", d, 32'h2000_0000);
    wr(8'h28, 0);
    rd(8'h08, d); check("R12 unmapped read", d, 0);
    wr(8'h08, 0);
    rd(8'h10, d); check("R12 unmapped write", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_level;
    t_edge;
    t_mask;
    t_msi;
    t_autoclr;
    t_abort;
    t_ctrl_store;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule